// File: doc/BRIEF.md
# Configurable Bidirectional GPIO Port

This block is one byte-wide parallel I/O port seen by a processor through three local data-memory offsets. Software sets up every pin on its own by pairing one bit of a mode register with the same bit of an output-value register. The pair selects one of four setups: a floating input, an input with a weak pull-up, a pin driven low, or a pin driven high. The block drives the pad controls for each pin: output enable, drive level and pull-up enable. A third offset returns the levels present on the pins after a two-stage synchronizer.

A parameter of enumerated type chooses one of three variants. The general port is the plain form above. The control port uses its two highest bits as chip controls instead of pins. Setting the top value bit requests the deepest sleep mode and setting the next bit requests the light sleep mode, each as a one-cycle pulse. The top two mode bits enable a start-up delay after deep sleep and select the alternate serial clock phase. The output-only port drives every pin at all times and comes out of reset driving all ones.

Top module: `pinport_top`

## Requirements
- R1: On reset, the general and control variants clear the mode and value registers, so each pin has output enable 0, pull-up 0 and drive 0, and offsets 0 and 1 read 0.
- R2: With mode bit 0, a pin is an input: value bit 0 gives pull-up 0 and value bit 1 gives pull-up 1. Output enable and pull-up are never both 1 on a pin.
- R3: With mode bit 1, a pin has output enable 1, pull-up 0, and drive equal to its value bit. A pin with output enable 0 has drive 0.
- R4: Every bit is set up independently of the others, so a mixed mode and value byte gives a different setup on each pin.
- R5: Offset 0 (mode) and offset 1 (value) can be written and read back. Offset 2 returns the pins and offset 3 returns 0. Writes to offsets 2 and 3 change nothing.
- R6: Offset 2 returns the pin inputs through two clock registers: a change is not seen after the first rising edge and is seen after the second.
- R7: Control variant: a write to offset 1 with bit 7 set makes deep_sleep_req 1 for exactly the following cycle, and a write with bit 6 set does the same for light_sleep_req. Another write is needed to request the mode again.
- R8: Control variant: mode bit 6 drives serial_clk_alt and mode bit 7 drives wake_delay_en, both held until rewritten.
- R9: Control variant: bits 7 and 6 read as 0 at offsets 0, 1 and 2, and pins 7 and 6 have output enable, drive and pull-up all 0.
- R10: Output-only variant: the value register resets to all ones, every pin has output enable 1 and pull-up 0, and drive equals the value register. Mode writes are ignored and offset 0 reads 0.
- R11: General and output-only variants hold deep_sleep_req, light_sleep_req, serial_clk_alt and wake_delay_en at 0 for any write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Local offset: 0 mode, 1 value, 2 pins, 3 unmapped |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data, combinational from bus_addr |
| pin_in | input | WIDTH | Pin levels from the pads |
| pin_oe | output | WIDTH | Per-pin output enable |
| pin_out | output | WIDTH | Per-pin drive level |
| pin_pull | output | WIDTH | Per-pin weak pull-up enable |
| deep_sleep_req | output | 1 | One-cycle deep sleep request (control variant) |
| light_sleep_req | output | 1 | One-cycle light sleep request (control variant) |
| serial_clk_alt | output | 1 | Alternate serial clock phase select (control variant) |
| wake_delay_en | output | 1 | Clock start-up delay after deep sleep (control variant) |

## Verification
The hard case is the control variant's request pulse. It is a one-cycle event that nothing stores, so it can only be seen in the cycle right after the write. The bench samples at the falling edge just after the write's rising edge, then again one cycle later to confirm the pulse has gone. It also writes a byte with neither request bit set to show that no pulse appears. The synchronizer delay is checked in the same way: the pins are read one cycle and two cycles after a change on pin_in.

// File: rtl/pinport_pkg.sv
package pinport_pkg;

    typedef enum logic [1:0] {
        KIND_GENERAL = 2'd0,
        KIND_CONTROL = 2'd1,
        KIND_OUTPUT  = 2'd2
    } port_kind_e;

    localparam int          OFS_W    = 2;
    localparam logic [1:0]  OFS_MODE = 2'd0;
    localparam logic [1:0]  OFS_VAL  = 2'd1;
    localparam logic [1:0]  OFS_PINS = 2'd2;

    typedef struct packed {
        logic oe;
        logic drv;
        logic pull;
    } pad_ctl_t;

    // Decode one pin's mode/value pair into pad controls.
    function automatic pad_ctl_t pad_decode(input logic mode_b, input logic val_b);
        pad_ctl_t p;
        p.oe   = mode_b;
        p.drv  = mode_b & val_b;
        p.pull = ~mode_b & val_b;
        return p;
    endfunction

    // Number of top bits that act as chip controls rather than pins.
    function automatic int ctrl_bits(input port_kind_e k);
        return (k == KIND_CONTROL) ? 2 : 0;
    endfunction

endpackage

// File: rtl/pinport_regs.sv
module pinport_regs
    import pinport_pkg::*;
#(
    parameter int         WIDTH = 8,
    parameter port_kind_e KIND  = KIND_GENERAL
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_mode,
    input  logic             wr_val,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] mode_q,
    output logic [WIDTH-1:0] val_q
);
    localparam logic [WIDTH-1:0] PIN_MASK   = {WIDTH{1'b1}} >> ctrl_bits(KIND);
    localparam logic [WIDTH-1:0] MODE_WMASK = (KIND == KIND_OUTPUT) ? '0 : '1;
    localparam logic [WIDTH-1:0] VAL_RST    = (KIND == KIND_OUTPUT) ? '1 : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            val_q  <= VAL_RST;
        end else begin
            if (wr_mode) mode_q <= wdata & MODE_WMASK;
            if (wr_val)  val_q  <= wdata & PIN_MASK;
        end
    end

endmodule

// File: rtl/pinport_sync.sv
module pinport_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end

endmodule

// File: rtl/pinport_pads.sv
module pinport_pads
    import pinport_pkg::*;
#(
    parameter int         WIDTH = 8,
    parameter port_kind_e KIND  = KIND_GENERAL
) (
    input  logic [WIDTH-1:0] mode_q,
    input  logic [WIDTH-1:0] val_q,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_pull
);
    localparam int  PIN_BITS = WIDTH - ctrl_bits(KIND);
    localparam bit  ALL_OUT  = (KIND == KIND_OUTPUT);

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        pad_ctl_t dec;
        always_comb begin
            dec = pad_decode(mode_q[i], val_q[i]);
            if (ALL_OUT) begin
                pin_oe[i]   = 1'b1;
                pin_out[i]  = val_q[i];
                pin_pull[i] = 1'b0;
            end else if (i >= PIN_BITS) begin
                pin_oe[i]   = 1'b0;
                pin_out[i]  = 1'b0;
                pin_pull[i] = 1'b0;
            end else begin
                pin_oe[i]   = dec.oe;
                pin_out[i]  = dec.drv;
                pin_pull[i] = dec.pull;
            end
        end
    end

endmodule

// File: rtl/pinport_ctrl.sv
module pinport_ctrl
    import pinport_pkg::*;
#(
    parameter int         WIDTH = 8,
    parameter port_kind_e KIND  = KIND_GENERAL
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_val,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] mode_q,
    output logic             deep_sleep_req,
    output logic             light_sleep_req,
    output logic             serial_clk_alt,
    output logic             wake_delay_en
);
    localparam bit IS_CTRL = (KIND == KIND_CONTROL);
    localparam int BIT_HI  = WIDTH - 1;
    localparam int BIT_LO  = WIDTH - 2;

    logic deep_q, light_q;

    // Request bits are never stored: they live for one cycle as a pulse.
    always_ff @(posedge clk) begin
        if (rst) begin
            deep_q  <= 1'b0;
            light_q <= 1'b0;
        end else begin
            deep_q  <= wr_val & wdata[BIT_HI];
            light_q <= wr_val & wdata[BIT_LO];
        end
    end

    assign deep_sleep_req  = IS_CTRL & deep_q;
    assign light_sleep_req = IS_CTRL & light_q;
    assign serial_clk_alt  = IS_CTRL & mode_q[BIT_LO];
    assign wake_delay_en   = IS_CTRL & mode_q[BIT_HI];

endmodule

// File: rtl/pinport_top.sv
module pinport_top
    import pinport_pkg::*;
#(
    parameter int         WIDTH = 8,
    parameter port_kind_e KIND  = KIND_GENERAL
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       bus_addr,
    input  logic             bus_we,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_pull,
    output logic             deep_sleep_req,
    output logic             light_sleep_req,
    output logic             serial_clk_alt,
    output logic             wake_delay_en
);
    localparam logic [WIDTH-1:0] PIN_MASK   = {WIDTH{1'b1}} >> ctrl_bits(KIND);
    localparam logic [WIDTH-1:0] MODE_RMASK = (KIND == KIND_OUTPUT) ? '0 : PIN_MASK;

    logic             wr_mode, wr_val;
    logic [WIDTH-1:0] mode_q, val_q, pins_sync;

    assign wr_mode = bus_we && (bus_addr == OFS_MODE);
    assign wr_val  = bus_we && (bus_addr == OFS_VAL);

    pinport_regs #(.WIDTH(WIDTH), .KIND(KIND)) regs_i (
        .clk(clk), .rst(rst), .wr_mode(wr_mode), .wr_val(wr_val),
        .wdata(bus_wdata), .mode_q(mode_q), .val_q(val_q)
    );

    pinport_sync #(.WIDTH(WIDTH)) sync_i (
        .clk(clk), .rst(rst), .async_in(pin_in), .sync_out(pins_sync)
    );

    pinport_pads #(.WIDTH(WIDTH), .KIND(KIND)) pads_i (
        .mode_q(mode_q), .val_q(val_q),
        .pin_oe(pin_oe), .pin_out(pin_out), .pin_pull(pin_pull)
    );

    pinport_ctrl #(.WIDTH(WIDTH), .KIND(KIND)) ctrl_i (
        .clk(clk), .rst(rst), .wr_val(wr_val), .wdata(bus_wdata), .mode_q(mode_q),
        .deep_sleep_req(deep_sleep_req), .light_sleep_req(light_sleep_req),
        .serial_clk_alt(serial_clk_alt), .wake_delay_en(wake_delay_en)
    );

    always_comb begin
        unique case (bus_addr)
            OFS_MODE: bus_rdata = mode_q & MODE_RMASK;
            OFS_VAL:  bus_rdata = val_q & PIN_MASK;
            OFS_PINS: bus_rdata = pins_sync & PIN_MASK;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pinport_checker.sv
module pinport_checker
    import pinport_pkg::*;
#(
    parameter int         WIDTH = 8,
    parameter port_kind_e KIND  = KIND_GENERAL
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       bus_addr,
    input logic             bus_we,
    input logic [WIDTH-1:0] bus_wdata,
    input logic [WIDTH-1:0] bus_rdata,
    input logic [WIDTH-1:0] pin_oe,
    input logic [WIDTH-1:0] pin_out,
    input logic [WIDTH-1:0] pin_pull,
    input logic             deep_sleep_req,
    input logic             light_sleep_req,
    input logic             serial_clk_alt,
    input logic             wake_delay_en
);
    localparam logic [WIDTH-1:0] PIN_MASK = {WIDTH{1'b1}} >> ctrl_bits(KIND);

    assert_oe_pull_excl_R2: assert property (@(posedge clk) disable iff (rst)
        (pin_oe & pin_pull) == '0);

    assert_drive_needs_oe_R3: assert property (@(posedge clk) disable iff (rst)
        (pin_out & ~pin_oe) == '0);

    assert_unmapped_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd3) |-> (bus_rdata == '0));

    assert_pins_write_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_PINS) |=> ($stable(pin_oe) && $stable(pin_pull) && $stable(pin_out)));

    if (KIND == KIND_OUTPUT) begin : g_out
        assert_all_driven_R10: assert property (@(posedge clk) disable iff (rst)
            (pin_oe == '1) && (pin_pull == '0));
        assert_val_write_R10: assert property (@(posedge clk) disable iff (rst)
            (bus_we && bus_addr == OFS_VAL) |=> (pin_out == $past(bus_wdata)));
    end else begin : g_io
        assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (pin_oe == '0 && pin_pull == '0 && pin_out == '0));
        assert_mode_write_R4: assert property (@(posedge clk) disable iff (rst)
            (bus_we && bus_addr == OFS_MODE) |=> (pin_oe == ($past(bus_wdata) & PIN_MASK)));
    end

    if (KIND == KIND_CONTROL) begin : g_ctl
        assert_deep_cause_R7: assert property (@(posedge clk) disable iff (rst)
            deep_sleep_req |-> $past(bus_we && bus_addr == OFS_VAL && bus_wdata[WIDTH-1]));
        assert_deep_single_R7: assert property (@(posedge clk) disable iff (rst)
            (deep_sleep_req && !(bus_we && bus_addr == OFS_VAL && bus_wdata[WIDTH-1])) |=> !deep_sleep_req);
        assert_light_cause_R7: assert property (@(posedge clk) disable iff (rst)
            light_sleep_req |-> $past(bus_we && bus_addr == OFS_VAL && bus_wdata[WIDTH-2]));
        assert_ctrl_pins_idle_R9: assert property (@(posedge clk) disable iff (rst)
            (pin_oe[WIDTH-1:WIDTH-2] == 2'b00) && (pin_pull[WIDTH-1:WIDTH-2] == 2'b00));
        assert_ctrl_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
            (bus_rdata[WIDTH-1:WIDTH-2] == 2'b00));
        assert_opts_hold_R8: assert property (@(posedge clk) disable iff (rst)
            !(bus_we && bus_addr == OFS_MODE) |=> ($stable(serial_clk_alt) && $stable(wake_delay_en)));
    end else begin : g_noctl
        assert_no_ctrl_R11: assert property (@(posedge clk) disable iff (rst)
            !deep_sleep_req && !light_sleep_req && !serial_clk_alt && !wake_delay_en);
    end

endmodule

bind pinport_top pinport_checker #(.WIDTH(WIDTH), .KIND(KIND)) chk_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_oe(pin_oe), .pin_out(pin_out), .pin_pull(pin_pull),
    .deep_sleep_req(deep_sleep_req), .light_sleep_req(light_sleep_req),
    .serial_clk_alt(serial_clk_alt), .wake_delay_en(wake_delay_en)
);

// File: tb/pinport_top_tb_top.sv
module pinport_top_tb_top;
    import pinport_pkg::*;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic [1:0]   addr;
    logic         we;
    logic [W-1:0] wdata, pin_in;

    logic [W-1:0] rd_g, oe_g, out_g, pull_g;
    logic         dsr_g, lsr_g, alt_g, dly_g;
    logic [W-1:0] rd_s, oe_s, out_s, pull_s;
    logic         dsr_s, lsr_s, alt_s, dly_s;
    logic [W-1:0] rd_o, oe_o, out_o, pull_o;
    logic         dsr_o, lsr_o, alt_o, dly_o;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;

    always #5 clk = ~clk;

    pinport_top #(.WIDTH(W), .KIND(KIND_GENERAL)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_rdata(rd_g), .pin_in(pin_in), .pin_oe(oe_g), .pin_out(out_g), .pin_pull(pull_g),
        .deep_sleep_req(dsr_g), .light_sleep_req(lsr_g), .serial_clk_alt(alt_g), .wake_delay_en(dly_g));

    pinport_top #(.WIDTH(W), .KIND(KIND_CONTROL)) dut_ctl_i (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_rdata(rd_s), .pin_in(pin_in), .pin_oe(oe_s), .pin_out(out_s), .pin_pull(pull_s),
        .deep_sleep_req(dsr_s), .light_sleep_req(lsr_s), .serial_clk_alt(alt_s), .wake_delay_en(dly_s));

    pinport_top #(.WIDTH(W), .KIND(KIND_OUTPUT)) dut_out_i (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_rdata(rd_o), .pin_in(pin_in), .pin_oe(oe_o), .pin_out(out_o), .pin_pull(pull_o),
        .deep_sleep_req(dsr_o), .light_sleep_req(lsr_o), .serial_clk_alt(alt_o), .wake_delay_en(dly_o));

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Returns at the falling edge just after the write's rising edge.
    task automatic bus_write(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [W-1:0] g, output logic [W-1:0] s, output logic [W-1:0] o);
        addr = a;
        #1;
        g = rd_g; s = rd_s; o = rd_o;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic t_reset();
        logic [W-1:0] g, s, o;
        chk("R1", "gen oe", oe_g, 8'h00);
        chk("R1", "gen pull", pull_g, 8'h00);
        chk("R1", "gen drive", out_g, 8'h00);
        bus_read(OFS_MODE, g, s, o);
        chk("R1", "gen mode read", g, 8'h00);
        chk("R1", "ctl mode read", s, 8'h00);
        bus_read(OFS_VAL, g, s, o);
        chk("R1", "gen value read", g, 8'h00);
        chk("R10", "out value reset", o, 8'hFF);
        chk("R10", "out oe reset", oe_o, 8'hFF);
        chk("R10", "out drive reset", out_o, 8'hFF);
        chk("R1", "ctl requests", {dsr_s, lsr_s, alt_s, dly_s}, 4'h0);
    endtask

    task automatic t_encoding();
        logic [W-1:0] g, s, o;
        bus_write(OFS_MODE, 8'hF0);
        bus_write(OFS_VAL, 8'hCC);
        chk("R3", "oe pattern1", oe_g, 8'hF0);
        chk("R2", "pull pattern1", pull_g, 8'h0C);
        chk("R3", "drive pattern1", out_g, 8'hC0);
        bus_read(OFS_MODE, g, s, o);
        chk("R5", "mode readback", g, 8'hF0);
        bus_read(OFS_VAL, g, s, o);
        chk("R5", "value readback", g, 8'hCC);
        bus_write(OFS_MODE, 8'h5A);
        bus_write(OFS_VAL, 8'h33);
        chk("R4", "oe pattern2", oe_g, 8'h5A);
        chk("R4", "pull pattern2", pull_g, 8'h21);
        chk("R4", "drive pattern2", out_g, 8'h12);
    endtask

    task automatic t_addr();
        logic [W-1:0] g, s, o;
        bus_write(OFS_PINS, 8'hFF);
        bus_write(2'd3, 8'hFF);
        chk("R5", "oe after ignored writes", oe_g, 8'h5A);
        chk("R5", "pull after ignored writes", pull_g, 8'h21);
        chk("R5", "drive after ignored writes", out_g, 8'h12);
        bus_read(2'd3, g, s, o);
        chk("R5", "offset3 gen", g, 8'h00);
        chk("R5", "offset3 ctl", s, 8'h00);
        chk("R5", "offset3 out", o, 8'h00);
    endtask

    task automatic t_sync();
        logic [W-1:0] g, s, o;
        @(negedge clk);
        pin_in = 8'h96;
        @(negedge clk);
        bus_read(OFS_PINS, g, s, o);
        chk("R6", "pins after one edge", g, 8'h00);
        @(negedge clk);
        bus_read(OFS_PINS, g, s, o);
        chk("R6", "pins after two edges", g, 8'h96);
        chk("R9", "ctl pins top bits zero", s, 8'h16);
        chk("R6", "out variant pins", o, 8'h96);
    endtask

    task automatic t_pulse();
        logic [W-1:0] g, s, o;
        bus_write(OFS_VAL, 8'h80);
        chk("R7", "deep pulse", dsr_s, 1'b1);
        chk("R7", "no light on deep", lsr_s, 1'b0);
        chk("R11", "gen no deep", dsr_g, 1'b0);
        chk("R11", "out no deep", dsr_o, 1'b0);
        @(negedge clk);
        chk("R7", "deep ends", dsr_s, 1'b0);
        bus_write(OFS_VAL, 8'h40);
        chk("R7", "light pulse", lsr_s, 1'b1);
        chk("R7", "no deep on light", dsr_s, 1'b0);
        @(negedge clk);
        chk("R7", "light ends", lsr_s, 1'b0);
        bus_write(OFS_VAL, 8'h3F);
        chk("R7", "no request without bits", {dsr_s, lsr_s}, 2'b00);
        bus_write(OFS_VAL, 8'hC5);
        chk("R7", "both requests", {dsr_s, lsr_s}, 2'b11);
        bus_read(OFS_VAL, g, s, o);
        chk("R9", "ctl value top bits zero", s, 8'h05);
    endtask

    task automatic t_options();
        logic [W-1:0] g, s, o;
        bus_write(OFS_MODE, 8'hFF);
        bus_write(OFS_VAL, 8'hFF);
        chk("R9", "ctl oe", oe_s, 8'h3F);
        chk("R9", "ctl drive", out_s, 8'h3F);
        chk("R9", "ctl pull", pull_s, 8'h00);
        chk("R8", "alt phase on", alt_s, 1'b1);
        chk("R8", "wake delay on", dly_s, 1'b1);
        chk("R11", "gen options off", {alt_g, dly_g}, 2'b00);
        bus_read(OFS_MODE, g, s, o);
        chk("R9", "ctl mode read", s, 8'h3F);
        chk("R10", "out mode reads zero", o, 8'h00);
        bus_write(OFS_MODE, 8'h40);
        chk("R8", "alt only", {alt_s, dly_s}, 2'b10);
        chk("R9", "ctl pull with mode 40", pull_s, 8'h3F);
        bus_write(OFS_MODE, 8'h80);
        chk("R8", "delay only", {alt_s, dly_s}, 2'b01);
    endtask

    task automatic t_output();
        logic [W-1:0] g, s, o;
        bus_write(OFS_MODE, 8'h00);
        chk("R10", "out oe ignores mode", oe_o, 8'hFF);
        bus_write(OFS_VAL, 8'h5A);
        chk("R10", "out drive", out_o, 8'h5A);
        chk("R10", "out pull", pull_o, 8'h00);
        chk("R10", "out oe", oe_o, 8'hFF);
        bus_read(OFS_VAL, g, s, o);
        chk("R10", "out value read", o, 8'h5A);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; we = 1'b0; addr = 2'd0; wdata = '0; pin_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_encoding();
        t_addr();
        t_sync();
        t_pulse();
        t_options();
        t_output();
        done = 1;
        summary();
        $finish;
    end

endmodule